// File: doc/BRIEF.md
# SRAM Power-Up and Power-Down Handshake Sequencer

This block drives the control bits of an SRAM macro inside a switchable power domain. A parent sequencer pulses a start request with a direction: power up or power down. The block writes the control bits and waits until the macro's acknowledge bits reach the expected level. It then answers with a single-cycle completion pulse. An error flag is set with that pulse if the acknowledge never arrives.

The block runs in one of two modes, picked by a static input:

- **Power-down mode.** A power-down control bit is held high while the SRAM is off. The expected acknowledge reads 1 when off and 0 when on.
- **Sleep mode.** A sleep control bit is held high while the SRAM is on. The expected acknowledge reads 1 when on and 0 when off.

The polarity therefore flips between the two modes. Each mode has its own control mask and acknowledge mask, set by parameters. Acknowledge bits outside the active mask are ignored.

A second static input enables two isolation outputs: an active-low internal isolation line and a clock isolation line. These are wrapped around the transition with a timed hold:

- **Power-down.** Clock isolation is raised first, then the internal isolation line is dropped. The sequencer then holds for about 1 µs before the power control changes.
- **Power-up.** After the acknowledge is met, the internal isolation line is released. About 1 µs later, clock isolation is released.

The acknowledge is polled:

- The first sample is taken on the cycle after the control write.
- Further samples follow once per poll interval (10 µs by default).
- After the number of samples that fits in the timeout (1 s by default), the operation ends with an error.
- On error, the control bits keep the value last written.

Top module: `sram_pwr_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs have these values:
  - The power-down control bits equal the power-down control mask, and the sleep control bits are 0.
  - The isolation outputs are active (internal isolation low, clock isolation high) when isolation is enabled, and inactive (internal isolation high, clock isolation low) when it is not.
  - `busy_o`, `done_o` and `err_o` are 0.
- R2: In power-down mode, a power-up request clears the masked power-down control bits. It completes when every acknowledge bit under the power-down acknowledge mask reads 0.
- R3: In power-down mode, a power-down request sets the masked power-down control bits. It completes when every acknowledge bit under the power-down acknowledge mask reads 1.
- R4: In sleep mode, the polarity is inverted:
  - A power-up request sets the masked sleep control bits and completes when every acknowledge bit under the sleep acknowledge mask reads 1.
  - A power-down request clears them and completes when those acknowledge bits read 0.
  - The power-down control bits never change in sleep mode.
- R5: Power-up with isolation enabled: on the cycle the acknowledge is met, the internal isolation line goes high. Exactly ISO_CYC cycles later, clock isolation goes low, and `done_o` pulses in that same cycle.
- R6: Power-down with isolation enabled: clock isolation goes high one cycle after start is accepted. The internal isolation line goes low one cycle after that. The control bits change exactly ISO_CYC cycles after the internal isolation line fell.
- R7: With isolation disabled, the isolation outputs never leave their inactive values.
- R8: The acknowledge is first sampled one cycle after the control write, and again every POLL_CYC cycles after that. `done_o` pulses on the first sampling cycle at which the acknowledge matches.
- R9: If MAX_POLLS samples all fail, the operation ends with `done_o` and `err_o` both high, (MAX_POLLS-1)*POLL_CYC+1 cycles after the control write. The control bits keep the value last written.
- R10: `err_o` stays high after a timeout until the next accepted start, which clears it one cycle after start is accepted.
- R11: Acknowledge bits outside the active mode's acknowledge mask have no effect on completion.
- R12: A start pulse while `busy_o` is high is ignored: it neither changes the outcome nor produces a second `done_o`.
- R13: `busy_o` is high from the cycle after start is accepted until completion. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| power_up_i | input | 1 | Direction of the request: 1 = power up, 0 = power down |
| sleep_mode_i | input | 1 | Static mode select: 1 = sleep mode, 0 = power-down mode |
| iso_en_i | input | 1 | Static enable for the isolation sequence |
| ack_i | input | W | Acknowledge bits from the SRAM macro |
| pdn_ctl_o | output | W | Power-down control bits |
| slp_ctl_o | output | W | Sleep control bits |
| iso_int_n_o | output | 1 | Internal isolation, active low |
| clk_iso_o | output | 1 | Clock isolation, active high |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Single-cycle completion pulse |
| err_o | output | 1 | Timeout flag, held until the next start |

## Verification
The bench measures the cycle distances between output edges:

- **Late acknowledge.** An acknowledge held off past the first sample must be caught on the next poll, 17 cycles after the write. A design that samples continuously, or that counts the interval wrongly, completes early or late.
- **Stuck acknowledge.** The acknowledge is held at the wrong level until the timeout. A design with an off-by-one sample count misses the exact completion time. A design that restores the control bits on error shows the wrong final value.
- **Isolation ordering and hold.** The order of the two isolation edges and the length of the hold are checked in both directions. Swapped edges, or a power change made before the hold ends, show up as wrong distances.
- **Garbage outside the mask.** Junk on the unmasked acknowledge bits must not stop completion, so a design that compares the whole vector would time out.
- **Start while busy.** A second start during an operation would produce a second completion or reverse the direction if it were accepted.

// File: rtl/sram_pwr_seq_pkg.sv
package sram_pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ISO_CLK  = 3'd1,
    ST_ISO_HOLD = 3'd2,
    ST_ACK_WAIT = 3'd3,
    ST_ISO_REL  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/sram_ack_match.sv
// Compares the masked acknowledge bits against the level the current
// mode and direction expect.
module sram_ack_match #(
  parameter int               W            = 8,
  parameter logic [W-1:0]     PDN_ACK_MASK = 8'h10,
  parameter logic [W-1:0]     SLP_ACK_MASK = 8'h20
) (
  input  logic [W-1:0] ack_i,
  input  logic         sleep_mode_i,
  input  logic         want_on_i,
  output logic         met_o
);

  logic [W-1:0] mask;
  logic         want_high;

  always_comb begin
    mask      = sleep_mode_i ? SLP_ACK_MASK : PDN_ACK_MASK;
    // sleep mode: on means acks high; power-down mode: on means acks low
    want_high = sleep_mode_i ? want_on_i : !want_on_i;
    met_o     = ((ack_i & mask) == (want_high ? mask : '0));
  end

endmodule

// File: rtl/sram_poll_timer.sv
// Paces acknowledge samples and counts them toward the timeout.
module sram_poll_timer #(
  parameter int POLL_CYC  = 1250,
  parameter int MAX_POLLS = 100000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic arm_i,
  input  logic run_i,
  output logic sample_o,
  output logic last_o
);

  localparam int CW = $clog2(POLL_CYC + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] RELOAD    = CW'(POLL_CYC - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

  logic [CW-1:0] intv_cnt;
  logic [PW-1:0] poll_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i || arm_i) begin
      intv_cnt <= '0;
      poll_cnt <= '0;
    end else if (run_i) begin
      if (intv_cnt == '0) begin
        intv_cnt <= RELOAD;
        poll_cnt <= poll_cnt + 1'b1;
      end else begin
        intv_cnt <= intv_cnt - 1'b1;
      end
    end
  end

  assign sample_o = run_i && (intv_cnt == '0);
  assign last_o   = (poll_cnt == LAST_POLL);

  // R9
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |-> (poll_cnt <= LAST_POLL));

endmodule

// File: rtl/sram_iso_delay.sv
// Hold timer for the isolation step; expires CYC cycles after a load.
module sram_iso_delay #(
  parameter int CYC = 125
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic load_i,
  output logic expired_o
);

  localparam int DW = $clog2(CYC + 1);
  localparam logic [DW-1:0] START = DW'(CYC - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i)            cnt <= '0;
    else if (load_i)      cnt <= START;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired_o = (cnt == '0);

endmodule

// File: rtl/sram_pwr_seq.sv
module sram_pwr_seq
  import sram_pwr_seq_pkg::*;
#(
  parameter int           W            = 8,
  parameter logic [W-1:0] PDN_CTL_MASK = 8'h01,
  parameter logic [W-1:0] PDN_ACK_MASK = 8'h10,
  parameter logic [W-1:0] SLP_CTL_MASK = 8'h02,
  parameter logic [W-1:0] SLP_ACK_MASK = 8'h20,
  parameter int           CLK_MHZ      = 125,
  parameter int           POLL_US      = 10,
  parameter int           TIMEOUT_US   = 1000000,
  parameter int           ISO_US       = 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic         power_up_i,
  input  logic         sleep_mode_i,
  input  logic         iso_en_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] pdn_ctl_o,
  output logic [W-1:0] slp_ctl_o,
  output logic         iso_int_n_o,
  output logic         clk_iso_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o
);

  localparam int POLL_CYC  = CLK_MHZ * POLL_US;
  localparam int MAX_POLLS = TIMEOUT_US / POLL_US;
  localparam int ISO_CYC   = CLK_MHZ * ISO_US;

  seq_state_e state;
  logic       dir_q;
  logic       met, sample, last_poll, iso_expired;
  logic       iso_load, poll_arm, accept;

  sram_ack_match #(
    .W(W), .PDN_ACK_MASK(PDN_ACK_MASK), .SLP_ACK_MASK(SLP_ACK_MASK)
  ) u_match (
    .ack_i(ack_i), .sleep_mode_i(sleep_mode_i), .want_on_i(dir_q), .met_o(met)
  );

  sram_poll_timer #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk_i(clk_i), .rst_i(rst_i), .arm_i(poll_arm),
    .run_i(state == ST_ACK_WAIT), .sample_o(sample), .last_o(last_poll)
  );

  sram_iso_delay #(.CYC(ISO_CYC)) u_iso (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(iso_load), .expired_o(iso_expired)
  );

  assign accept   = (state == ST_IDLE) && start_i;
  assign poll_arm = (accept && (power_up_i || !iso_en_i)) ||
                    ((state == ST_ISO_HOLD) && iso_expired);
  assign iso_load = (state == ST_ISO_CLK) ||
                    ((state == ST_ACK_WAIT) && sample && met && dir_q && iso_en_i);
  assign busy_o   = (state != ST_IDLE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state       <= ST_IDLE;
      dir_q       <= 1'b0;
      pdn_ctl_o   <= PDN_CTL_MASK;
      slp_ctl_o   <= '0;
      iso_int_n_o <= !iso_en_i;
      clk_iso_o   <= iso_en_i;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            err_o <= 1'b0;
            dir_q <= power_up_i;
            if (power_up_i || !iso_en_i) begin
              if (sleep_mode_i)
                slp_ctl_o <= power_up_i ? (slp_ctl_o | SLP_CTL_MASK)
                                        : (slp_ctl_o & ~SLP_CTL_MASK);
              else
                pdn_ctl_o <= power_up_i ? (pdn_ctl_o & ~PDN_CTL_MASK)
                                        : (pdn_ctl_o | PDN_CTL_MASK);
              state <= ST_ACK_WAIT;
            end else begin
              clk_iso_o <= 1'b1;
              state     <= ST_ISO_CLK;
            end
          end
        end
        ST_ISO_CLK: begin
          iso_int_n_o <= 1'b0;
          state       <= ST_ISO_HOLD;
        end
        ST_ISO_HOLD: begin
          if (iso_expired) begin
            if (sleep_mode_i) slp_ctl_o <= slp_ctl_o & ~SLP_CTL_MASK;
            else              pdn_ctl_o <= pdn_ctl_o | PDN_CTL_MASK;
            state <= ST_ACK_WAIT;
          end
        end
        ST_ACK_WAIT: begin
          if (sample) begin
            if (met) begin
              if (dir_q && iso_en_i) begin
                iso_int_n_o <= 1'b1;
                state       <= ST_ISO_REL;
              end else begin
                done_o <= 1'b1;
                state  <= ST_IDLE;
              end
            end else if (last_poll) begin
              err_o  <= 1'b1;
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        ST_ISO_REL: begin
          if (iso_expired) begin
            clk_iso_o <= 1'b0;
            done_o    <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R4
  sleep_pdn_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (sleep_mode_i && $past(sleep_mode_i)) |-> $stable(pdn_ctl_o));

  // R5
  clk_iso_rel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(clk_iso_o) |-> (iso_int_n_o && done_o));

  // R6
  iso_int_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(iso_int_n_o) |-> clk_iso_o);

  // R7
  no_iso_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !iso_en_i |-> (iso_int_n_o && !clk_iso_o));

  // R10
  err_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(err_o) |-> done_o);

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));

endmodule

// File: tb/sram_pwr_seq_tb_top.sv
module sram_pwr_seq_tb_top;

  typedef struct {
    logic       err;
    logic [7:0] pdn;
    logic [7:0] slp;
    logic       ison;
    logic       ciso;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       pwr_up = 1'b0;
  logic       sleep_m = 1'b0;
  logic       iso_en = 1'b0;
  logic       force_en = 1'b0;
  logic [7:0] force_val = 8'h00;
  logic [7:0] ack;
  logic [7:0] pdn, slp;
  logic       ison, ciso, busy, done, err;

  int n_vec = 0, n_bad = 0, cyc = 0, smp = 0, done_cnt = 0;
  int t_ctl = 0, t_inf = 0, t_inr = 0, t_cir = 0, t_cif = 0, t_done = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  // Macro model: pdn ack (bit 4) follows pdn ctl bit 0, sleep ack (bit 5) follows slp ctl bit 1
  assign ack = force_en ? force_val : {2'b00, slp[1], pdn[0], 4'b0000};

  sram_pwr_seq #(.CLK_MHZ(4), .POLL_US(2), .TIMEOUT_US(10), .ISO_US(1)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .power_up_i(pwr_up),
    .sleep_mode_i(sleep_m), .iso_en_i(iso_en), .ack_i(ack),
    .pdn_ctl_o(pdn), .slp_ctl_o(slp), .iso_int_n_o(ison), .clk_iso_o(ciso),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: timestamps output edges and pops the scoreboard on completion
  logic [7:0] p_pdn = 8'h00, p_slp = 8'h00;
  logic       p_ison = 1'b0, p_ciso = 1'b0;
  always @(negedge clk) begin
    smp++;
    if (!rst) begin
      if (pdn != p_pdn || slp != p_slp) t_ctl = smp;
      if (p_ison && !ison) t_inf = smp;
      if (!p_ison && ison) t_inr = smp;
      if (!p_ciso && ciso) t_cir = smp;
      if (p_ciso && !ciso) t_cif = smp;
      if (done) begin
        exp_t e;
        t_done = smp;
        done_cnt++;
        if (sb_q.size() == 0) begin
          chk(0, "R12", "unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(err == e.err, e.req, "err", err, e.err);
          chk(pdn == e.pdn, e.req, "pdn ctl", pdn, e.pdn);
          chk(slp == e.slp, e.req, "slp ctl", slp, e.slp);
          chk(ison == e.ison && ciso == e.ciso, e.req, "iso pair",
              {ison, ciso}, {e.ison, e.ciso});
        end
      end
    end
    p_pdn = pdn; p_slp = slp; p_ison = ison; p_ciso = ciso;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic do_reset(input logic sm, input logic ie);
    sleep_m = sm; iso_en = ie; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pdn == 8'h01 && slp == 8'h00, "R1", "ctl after reset", {pdn, slp}, 16'h0100);
    chk(ison == !ie && ciso == ie, "R1", "iso after reset", {ison, ciso}, {!ie, ie});
    chk(!busy && !done && !err, "R1", "flags after reset", {busy, done, err}, 0);
  endtask

  task automatic run_op(input logic up, input exp_t e, input logic fen,
                        input logic [7:0] fv, input int rel, input bit extra);
    int d0 = done_cnt;
    sb_q.push_back(e);
    force_val = fv; force_en = fen;
    pwr_up = up; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R13 busy after accept, R10 err cleared by start
    chk(busy == 1'b1, "R13", "busy after start", busy, 1);
    chk(err == 1'b0, "R10", "err cleared by start", err, 0);
    if (extra) begin
      pwr_up = !up; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (rel > 0) begin
      repeat (rel) @(negedge clk);
      force_en = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    force_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, "R12", "done count", done_cnt - d0, 1);
    chk(!busy, "R13", "idle after done", busy, 0);
  endtask

  initial begin
    exp_t e;
    @(negedge clk);

    // Power-down mode, isolation off
    do_reset(1'b0, 1'b0);
    e = '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R2"};
    run_op(1'b1, e, 1'b0, 8'h00, 0, 0);
    chk(t_done - t_ctl == 1, "R8", "first sample latency", t_done - t_ctl, 1);

    e = '{1'b0, 8'h01, 8'h00, 1'b1, 1'b0, "R3"};
    run_op(1'b0, e, 1'b0, 8'h00, 0, 0);
    chk(t_done - t_ctl == 1, "R3", "down latency", t_done - t_ctl, 1);

    // late ack plus ignored start while busy (R12, R7 iso untouched)
    e = '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R8"};
    run_op(1'b1, e, 1'b1, 8'h10, 8, 1);
    chk(t_done - t_ctl == 17, "R8", "late ack poll latency", t_done - t_ctl, 17);

    // stuck ack -> timeout
    e = '{1'b1, 8'h01, 8'h00, 1'b1, 1'b0, "R9"};
    run_op(1'b0, e, 1'b1, 8'h00, 0, 0);
    chk(t_done - t_ctl == 33, "R9", "timeout latency", t_done - t_ctl, 33);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R10", "err held", err, 1);

    // unmasked garbage ignored
    e = '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R11"};
    run_op(1'b1, e, 1'b1, 8'hEF, 0, 0);
    chk(t_done - t_ctl == 1, "R11", "masked match latency", t_done - t_ctl, 1);

    // Sleep mode, isolation on
    do_reset(1'b1, 1'b1);
    e = '{1'b0, 8'h01, 8'h02, 1'b1, 1'b0, "R4"};
    run_op(1'b1, e, 1'b0, 8'h00, 0, 0);
    chk(t_inr - t_ctl == 1, "R5", "iso release at ack", t_inr - t_ctl, 1);
    chk(t_cif - t_inr == 4, "R5", "clk iso hold", t_cif - t_inr, 4);
    chk(t_done == t_cif, "R5", "done with clk iso release", t_done - t_cif, 0);

    e = '{1'b0, 8'h01, 8'h00, 1'b0, 1'b1, "R4"};
    run_op(1'b0, e, 1'b0, 8'h00, 0, 0);
    chk(t_inf - t_cir == 1, "R6", "iso order", t_inf - t_cir, 1);
    chk(t_ctl - t_inf == 4, "R6", "hold before power change", t_ctl - t_inf, 4);
    chk(t_done - t_ctl == 1, "R4", "sleep down latency", t_done - t_ctl, 1);

    // sleep up stuck: ctl kept, isolation not released
    e = '{1'b1, 8'h01, 8'h02, 1'b0, 1'b1, "R9"};
    run_op(1'b1, e, 1'b1, 8'h00, 0, 0);
    chk(t_done - t_ctl == 33, "R9", "sleep timeout latency", t_done - t_ctl, 33);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule